// File: doc/BRIEF.md
# Overlaid Packed/Float Register Bank

This block holds eight 80-bit floating-point slots. Packed-integer operations see the same storage as eight 64-bit registers: packed register n is the low 64 bits of slot n. The storage is shared, so a value written through one view is the value read through the other. The packed view has two combinational read ports and one write port. The floating-point view has one combined read/write port.

A two-state mode machine controls the floating-point port. Any packed read or write is accepted in either mode and moves the bank into packed mode. While packed mode is active, every floating-point access is refused and raises a fault pulse. The exit command wipes all slots to zero and returns the bank to floating-point mode. Floating-point contents are therefore lost across a packed sequence.

A packed write fills the upper 16 bits of its slot with ones. The bank holds data only and has no path to address generation.

Top module: `overlay_regbank`

## Requirements
- R1: After reset the bank is in floating-point mode (`packedMode`=0), `flFault` is 0, and every packed read port returns zero.
- R2: A packed write to register n stores `pkWrData` in the low 64 bits of slot n. From the next clock edge that value appears on any packed read port addressed to n.
- R3: The two packed read ports are combinational and independent: each returns the low 64 bits of the slot it addresses, in the same cycle.
- R4: In floating-point mode, a floating-point write (`flEn`=1, `flWe`=1) stores all 80 bits of `flWrData` in slot `flAddr`. From the next edge, `flRdData` returns those 80 bits and the packed ports return their low 64 bits.
- R5: A packed read strobe or packed write is accepted in either mode. If no exit is issued in the same cycle, `packedMode` is 1 from the next edge.
- R6: A floating-point access while `packedMode`=1 is refused. No slot changes, `flRdData` reads zero in that cycle, and `flFault` is 1 for exactly the one cycle after each attempt.
- R7: The exit command clears every slot to zero and sets `packedMode` to 0 at the next edge.
- R8: The exit command takes priority over a packed write or a floating-point write in the same cycle. Neither write lands.
- R9: When a packed write and a floating-point write target the same slot in the same cycle in floating-point mode, the packed write determines the low 64 bits.
- R10: A write is not visible in the cycle of its strobe. Reads in that cycle return the previous contents.
- R11: A floating-point access in floating-point mode raises no fault and leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pkRdEn | input | 1 | Packed read operation strobe |
| pkRdAddrA | input | 3 | Packed read port A register number |
| pkRdDataA | output | 64 | Packed read port A data |
| pkRdAddrB | input | 3 | Packed read port B register number |
| pkRdDataB | output | 64 | Packed read port B data |
| pkWrEn | input | 1 | Packed write strobe |
| pkWrAddr | input | 3 | Packed write register number |
| pkWrData | input | 64 | Packed write data |
| flEn | input | 1 | Floating-point access strobe |
| flWe | input | 1 | Floating-point access is a write when 1 |
| flAddr | input | 3 | Floating-point slot number |
| flWrData | input | 80 | Floating-point write data |
| flRdData | output | 80 | Floating-point read data, zero when refused |
| exitCmd | input | 1 | Clear all slots and return to floating-point mode |
| packedMode | output | 1 | 1 while packed mode is active |
| flFault | output | 1 | One-cycle pulse after a refused floating-point access |

## Verification
A wrong mode state shows up within one cycle on the ports. `packedMode` changes value, and the next floating-point access either gives a spurious `flFault` pulse with zero read data, or misses a fault it should have raised. A slot corrupted by a write that should have been dropped, or by an incomplete clear, shows up on the packed read ports as soon as that register is addressed. The tests therefore read back through the packed ports the slots touched by refused, colliding and exit-shadowed writes, one cycle after the stimulus.

// File: rtl/overlay_pkg.sv
package overlay_pkg;

  typedef enum logic {
    MODE_FLOAT  = 1'b0,
    MODE_PACKED = 1'b1
  } bankMode_e;

  typedef struct packed {
    logic clearAll;
    logic pkWr;
    logic flWr;
    logic flRdOk;
  } ctrlStrobes_t;

endpackage

// File: rtl/overlay_ctrl.sv
module overlay_ctrl
  import overlay_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pkRdEn,
  input  logic         pkWrEn,
  input  logic         flEn,
  input  logic         flWe,
  input  logic         exitCmd,
  output ctrlStrobes_t strobes,
  output logic         packedMode,
  output logic         flFault
);

  bankMode_e modeQ, modeD;
  logic      faultQ;
  logic      pkOp;
  logic      inPacked;

  always_comb begin
    pkOp     = pkRdEn | pkWrEn;
    inPacked = (modeQ == MODE_PACKED);

    // exit outranks every write
    strobes.clearAll = exitCmd;
    strobes.pkWr     = pkWrEn & ~exitCmd;
    strobes.flWr     = flEn & flWe & ~inPacked & ~exitCmd;
    strobes.flRdOk   = flEn & ~inPacked;

    modeD = modeQ;
    if (exitCmd)   modeD = MODE_FLOAT;
    else if (pkOp) modeD = MODE_PACKED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_FLOAT;
      faultQ <= 1'b0;
    end else begin
      modeQ  <= modeD;
      faultQ <= flEn & inPacked;
    end
  end

  assign packedMode = inPacked;
  assign flFault    = faultQ;

  // R7: exit always lands in float mode
  p_exit_float_r7: assert property (@(posedge clk) disable iff (!rstN)
    exitCmd |=> !packedMode);

  // R5: packed op without exit enters packed mode
  p_enter_packed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pkOp && !exitCmd) |=> packedMode);

  // R6: refused float access pulses the fault
  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flEn && packedMode) |=> flFault);

  // R11: no fault without a refused attempt
  p_no_fault_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(flEn && packedMode) |=> !flFault);

  // R11: float access alone does not move the mode
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!pkOp && !exitCmd) |=> $stable(packedMode));

endmodule

// File: rtl/overlay_dp.sv
module overlay_dp
  import overlay_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 80,
  parameter int LANE_W    = 64,
  localparam int ADDR_W   = $clog2(NUM_SLOTS),
  localparam int TAG_W    = SLOT_W - LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] pkRdAddrA,
  input  logic [ADDR_W-1:0] pkRdAddrB,
  input  logic [ADDR_W-1:0] pkWrAddr,
  input  logic [LANE_W-1:0] pkWrData,
  input  logic [ADDR_W-1:0] flAddr,
  input  logic [SLOT_W-1:0] flWrData,
  output logic [LANE_W-1:0] pkRdDataA,
  output logic [LANE_W-1:0] pkRdDataB,
  output logic [SLOT_W-1:0] flRdData
);

  logic [SLOT_W-1:0] slotQ [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic pkHit, flHit;
    assign pkHit = strobes.pkWr && (pkWrAddr == ADDR_W'(i));
    assign flHit = strobes.flWr && (flAddr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 slotQ[i] <= '0;
      else if (strobes.clearAll) slotQ[i] <= '0;
      else if (pkHit)            slotQ[i] <= {{TAG_W{1'b1}}, pkWrData};
      else if (flHit)            slotQ[i] <= flWrData;
    end

    // R7: exit leaves each slot zero
    p_clear_slot_r7: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clearAll |=> (slotQ[i] == '0));

    // R2: packed write tags the upper bits with ones and stores the lane
    p_pk_tag_r2: assert property (@(posedge clk) disable iff (!rstN)
      pkHit |=> (slotQ[i] == {{TAG_W{1'b1}}, $past(pkWrData)}));

    // R4: float write stores the full width
    p_fl_full_r4: assert property (@(posedge clk) disable iff (!rstN)
      (flHit && !pkHit) |=> (slotQ[i] == $past(flWrData)));
  end

  assign pkRdDataA = slotQ[pkRdAddrA][LANE_W-1:0];
  assign pkRdDataB = slotQ[pkRdAddrB][LANE_W-1:0];
  assign flRdData  = strobes.flRdOk ? slotQ[flAddr] : '0;

  // R6: a refused float access returns zero
  p_refused_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flRdOk |-> (flRdData == '0));

endmodule

// File: rtl/overlay_regbank.sv
module overlay_regbank
  import overlay_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 80,
  parameter int LANE_W    = 64,
  localparam int ADDR_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pkRdEn,
  input  logic [ADDR_W-1:0] pkRdAddrA,
  output logic [LANE_W-1:0] pkRdDataA,
  input  logic [ADDR_W-1:0] pkRdAddrB,
  output logic [LANE_W-1:0] pkRdDataB,
  input  logic              pkWrEn,
  input  logic [ADDR_W-1:0] pkWrAddr,
  input  logic [LANE_W-1:0] pkWrData,
  input  logic              flEn,
  input  logic              flWe,
  input  logic [ADDR_W-1:0] flAddr,
  input  logic [SLOT_W-1:0] flWrData,
  output logic [SLOT_W-1:0] flRdData,
  input  logic              exitCmd,
  output logic              packedMode,
  output logic              flFault
);

  ctrlStrobes_t strobes;

  overlay_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pkRdEn    (pkRdEn),
    .pkWrEn    (pkWrEn),
    .flEn      (flEn),
    .flWe      (flWe),
    .exitCmd   (exitCmd),
    .strobes   (strobes),
    .packedMode(packedMode),
    .flFault   (flFault)
  );

  overlay_dp #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .LANE_W   (LANE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pkRdAddrA(pkRdAddrA),
    .pkRdAddrB(pkRdAddrB),
    .pkWrAddr (pkWrAddr),
    .pkWrData (pkWrData),
    .flAddr   (flAddr),
    .flWrData (flWrData),
    .pkRdDataA(pkRdDataA),
    .pkRdDataB(pkRdDataB),
    .flRdData (flRdData)
  );

endmodule

// File: tb/sim_overlay_regbank.sv
module sim_overlay_regbank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pkRdEn = 0, pkWrEn = 0, flEn = 0, flWe = 0, exitCmd = 0;
  logic [2:0]  pkRdAddrA = 0, pkRdAddrB = 0, pkWrAddr = 0, flAddr = 0;
  logic [63:0] pkWrData = 0;
  logic [79:0] flWrData = 0;
  logic [63:0] pkRdDataA, pkRdDataB;
  logic [79:0] flRdData;
  logic        packedMode, flFault;

  int nVec = 0;
  int nBad = 0;

  localparam logic [79:0] FL_A  = 80'hABCD_0123_4567_89AB_CDEF;
  localparam logic [79:0] FL_B  = 80'h7777_FEED_FACE_0000_1111;
  localparam logic [63:0] PK_A  = 64'h0F1E_2D3C_4B5A_6978;
  localparam logic [63:0] PK_B  = 64'hDEAD_BEEF_0BAD_F00D;

  always #4 clk = ~clk;

  overlay_regbank u0 (
    .clk(clk), .rstN(rstN),
    .pkRdEn(pkRdEn), .pkRdAddrA(pkRdAddrA), .pkRdDataA(pkRdDataA),
    .pkRdAddrB(pkRdAddrB), .pkRdDataB(pkRdDataB),
    .pkWrEn(pkWrEn), .pkWrAddr(pkWrAddr), .pkWrData(pkWrData),
    .flEn(flEn), .flWe(flWe), .flAddr(flAddr), .flWrData(flWrData),
    .flRdData(flRdData), .exitCmd(exitCmd),
    .packedMode(packedMode), .flFault(flFault)
  );

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one edge, land 1 ns after it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    pkRdEn = 0; pkWrEn = 0; flEn = 0; flWe = 0; exitCmd = 0;
  endtask

  task automatic t_reset();
    pkRdAddrA = 3'd3; pkRdAddrB = 3'd6; #1;
    chk("R1 mode", {79'd0, packedMode}, 80'd0);
    chk("R1 fault", {79'd0, flFault}, 80'd0);
    chk("R1 readA", {16'd0, pkRdDataA}, 80'd0);
    chk("R1 readB", {16'd0, pkRdDataB}, 80'd0);
  endtask

  task automatic t_float_write();
    flEn = 1; flWe = 1; flAddr = 3'd2; flWrData = FL_A; #1;
    chk("R10 fl same-cycle old", flRdData, 80'd0);
    tick();
    flWe = 0; #1;
    chk("R4 fl readback", flRdData, FL_A);
    pkRdAddrA = 3'd2; #1;
    chk("R4 low lane on packed", {16'd0, pkRdDataA}, {16'd0, FL_A[63:0]});
    chk("R11 mode unchanged", {79'd0, packedMode}, 80'd0);
    tick();
    chk("R11 no fault", {79'd0, flFault}, 80'd0);
    idle();
  endtask

  task automatic t_packed_read();
    pkRdEn = 1; pkRdAddrA = 3'd2; pkRdAddrB = 3'd0; #1;
    chk("R3 port A", {16'd0, pkRdDataA}, {16'd0, FL_A[63:0]});
    chk("R3 port B", {16'd0, pkRdDataB}, 80'd0);
    tick();
    idle(); #1;
    chk("R5 enters packed", {79'd0, packedMode}, 80'd1);
  endtask

  task automatic t_refused();
    flEn = 1; flWe = 1; flAddr = 3'd2; flWrData = FL_B; #1;
    chk("R6 refused read zero", flRdData, 80'd0);
    tick();
    idle(); #1;
    chk("R6 fault pulse", {79'd0, flFault}, 80'd1);
    pkRdAddrA = 3'd2; #1;
    chk("R6 slot unchanged", {16'd0, pkRdDataA}, {16'd0, FL_A[63:0]});
    tick();
    chk("R6 pulse one cycle", {79'd0, flFault}, 80'd0);
  endtask

  task automatic t_packed_write();
    pkWrEn = 1; pkWrAddr = 3'd5; pkWrData = PK_A; pkRdAddrB = 3'd5; #1;
    chk("R10 pk same-cycle old", {16'd0, pkRdDataB}, 80'd0);
    tick();
    idle(); #1;
    chk("R2 pk readback", {16'd0, pkRdDataB}, {16'd0, PK_A});
    chk("R5 still packed", {79'd0, packedMode}, 80'd1);
  endtask

  task automatic t_exit();
    exitCmd = 1;
    tick();
    idle(); pkRdAddrA = 3'd2; pkRdAddrB = 3'd5; #1;
    chk("R7 float mode", {79'd0, packedMode}, 80'd0);
    chk("R7 slot2 clear", {16'd0, pkRdDataA}, 80'd0);
    chk("R7 slot5 clear", {16'd0, pkRdDataB}, 80'd0);
    flEn = 1; flAddr = 3'd2; #1;
    chk("R7 fl view clear", flRdData, 80'd0);
    tick();
    idle(); #1;
    chk("R11 no fault after exit", {79'd0, flFault}, 80'd0);
  endtask

  task automatic t_exit_priority();
    pkWrEn = 1; pkWrAddr = 3'd6; pkWrData = PK_B;
    flEn = 1; flWe = 1; flAddr = 3'd1; flWrData = FL_B; exitCmd = 1;
    tick();
    idle(); pkRdAddrA = 3'd6; pkRdAddrB = 3'd1; #1;
    chk("R8 packed write dropped", {16'd0, pkRdDataA}, 80'd0);
    chk("R8 float write dropped", {16'd0, pkRdDataB}, 80'd0);
    chk("R8 mode float", {79'd0, packedMode}, 80'd0);
  endtask

  task automatic t_collision();
    pkWrEn = 1; pkWrAddr = 3'd7; pkWrData = PK_B;
    flEn = 1; flWe = 1; flAddr = 3'd7; flWrData = FL_A;
    tick();
    idle(); pkRdAddrA = 3'd7; #1;
    chk("R9 packed wins", {16'd0, pkRdDataA}, {16'd0, PK_B});
    chk("R5 collision enters packed", {79'd0, packedMode}, 80'd1);
    exitCmd = 1;
    tick();
    idle();
  endtask

  initial begin : watchdog
    #(8 * 20000);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #20 rstN = 1'b1;
    tick();
    t_reset();
    t_float_write();
    t_packed_read();
    t_refused();
    t_packed_write();
    t_exit();
    t_exit_priority();
    t_collision();
    tick();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule